// File: doc/BRIEF.md
# Prescaled Reload Down-Timer

This block holds two independent 16-bit down-counting timers that share one prescaler. The prescaler runs from reset and emits a one-cycle tick every 20 system clock cycles. An enabled channel moves its counter one step on each tick. When a counter steps from 1 to 0, this is a zero event. The channel then sets its status flag. On the next tick the counter reloads from its reload register, so a reload value of N gives a period of N+1 ticks.

Software reaches the timers through a small word-wide register port. It can write and read both counters and both reload registers, a control word and a status word. The status word is cleared when it is read. A single interrupt line goes high while any flag is set and its channel's interrupt enable is on. Channel 1 also drives a waveform pin. On each of its zero events the pin holds, toggles, goes low or goes high, as the control word selects.

Top module: `reload_timer_top`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `wave_o` is 0.
- R2: An enabled channel's counter steps down by exactly 1 once every 20 clock cycles.
- R3: A counter at 0 loads its reload value on its next tick. With count 2 and reload 3, the values seen are 1, 0, 3, 2, 1, 0, 3.
- R4: A zero event sets a status bit: bit 0 for channel 0 and bit 1 for channel 1. Reading the status word returns these bits and clears them. A zero event in the same cycle as the read takes priority.
- R5: `irq_o` is high while a status bit is set and the matching interrupt enable is set. An enable that is off keeps `irq_o` low, but the flag is still recorded.
- R6: While a channel is disabled, its counter holds its value. A write to the count register replaces the value and reads back.
- R7: A reload value written while the channel runs leaves the present count alone. It is used only at the next reload.
- R8: Control bits [5:4] set what `wave_o` does on each channel 1 zero event: 0 hold, 1 toggle, 2 drive low, 3 drive high. Channel 0 zero events leave `wave_o` unchanged.
- R9: Both channels step on the same shared prescaler ticks. A channel enabled at any cycle steps in phase with the other.
- R10: Register addresses are: 0 count of channel 0, 1 reload of channel 0, 2 count of channel 1, 3 reload of channel 1, 4 control, 5 status. Control bit 0 enables channel 0 and bit 1 enables channel 1. Bits 2 and 3 are their interrupt enables. `rdata` shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; a read of status clears it at the clock edge |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request |
| wave_o | output | 1 | Channel 1 waveform output |

## Verification
The counter is watched at every cycle with a long start count. This shows whether the step size and the 20-cycle spacing are right, and it is kept apart from reload effects. Short count and reload pairs make the counter wrap several times. That sequence shows whether the reload comes one tick after zero or on the zero tick itself, and whether a reload written mid-run is picked up early. The waveform pin is driven through all four modes in turn. Channel 0 is then run alone, which separates a channel 1 zero event from any zero event. Last, channel 1 is enabled at an odd cycle offset, and its step cycle is compared modulo 20 with channel 0. A private per-channel divider would show up there.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT0 = 3'd0,
    A_RLD0 = 3'd1,
    A_CNT1 = 3'd2,
    A_RLD1 = 3'd3,
    A_CTRL = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    WM_HOLD   = 2'd0,
    WM_TOGGLE = 2'd1,
    WM_LOW    = 2'd2,
    WM_HIGH   = 2'd3
  } wave_mode_e;

  typedef struct packed {
    wave_mode_e mode;
    logic [1:0] ie;
    logic [1:0] en;
  } ctrl_t;
endpackage

// File: rtl/rt_reset_sync.sv
module rt_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q, div_d;

  always_comb begin
    tick_o = (div_q == LAST);
    div_d  = tick_o ? '0 : div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)
        else $error("prescaler tick on consecutive cycles");
    end
  endgenerate
endmodule

// File: rtl/rt_channel.sv
module rt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic             flag_clr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             flag_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             flag_q, flag_d;
  logic             step;

  always_comb begin
    step   = tick_i && en_i && !cnt_we_i;
    cnt_d  = cnt_q;
    zero_o = 1'b0;
    if (cnt_we_i) begin
      cnt_d = wdata_i;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d = rld_q;
      end else begin
        cnt_d  = cnt_q - ONE;
        zero_o = (cnt_q == ONE);
      end
    end
    rld_d  = rld_we_i ? wdata_i : rld_q;
    flag_d = zero_o ? 1'b1 : (flag_clr_i ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign flag_o = flag_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !cnt_we_i) |=> $stable(cnt_o))
    else $error("disabled counter moved");

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_i && !cnt_we_i && cnt_o != '0) |=> (cnt_o == CNT_W'($past(cnt_o) - ONE)))
    else $error("counter did not step down by one");

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_i && !cnt_we_i && cnt_o == '0) |=> (cnt_o == $past(rld_o)))
    else $error("counter did not reload");

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |=> flag_o)
    else $error("zero event lost");
endmodule

// File: rtl/rt_wave.sv
module rt_wave (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_i,
  input  rt_pkg::wave_mode_e mode_i,
  output logic              wave_o
);
  import rt_pkg::*;

  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (zero_i) begin
      unique case (mode_i)
        WM_HOLD:   wave_d = wave_q;
        WM_TOGGLE: wave_d = !wave_q;
        WM_LOW:    wave_d = 1'b0;
        WM_HIGH:   wave_d = 1'b1;
        default:   wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave_o = wave_q;

  assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_i && mode_i == WM_HIGH) |=> wave_o)
    else $error("wave not driven high");

  assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_i && mode_i == WM_LOW) |=> !wave_o)
    else $error("wave not driven low");

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_i |=> $stable(wave_o))
    else $error("wave moved without a zero event");
endmodule

// File: rtl/reload_timer_top.sv
module reload_timer_top #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_o,
  output logic             wave_o
);
  import rt_pkg::*;

  localparam int NUM_CH = 2;
  localparam int CTL_W  = $bits(ctrl_t);

  logic              srst_n;
  logic              tick;
  ctrl_t             ctrl_q, ctrl_d;
  logic              stat_rd;
  logic [NUM_CH-1:0] flag, zero;
  logic [CNT_W-1:0]  cnt  [NUM_CH];
  logic [CNT_W-1:0]  rld  [NUM_CH];

  rt_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  rt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(srst_n), .tick_o(tick)
  );

  always_comb begin
    stat_rd = rd_en && (addr == A_STAT);
    ctrl_d  = (wr_en && addr == A_CTRL) ? ctrl_t'(wdata[CTL_W-1:0]) : ctrl_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic cnt_we, rld_we;
      assign cnt_we = wr_en && (addr == 3'(2 * g));
      assign rld_we = wr_en && (addr == 3'(2 * g + 1));

      rt_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(srst_n), .tick_i(tick),
        .en_i(ctrl_q.en[g]), .cnt_we_i(cnt_we), .rld_we_i(rld_we),
        .flag_clr_i(stat_rd), .wdata_i(wdata),
        .cnt_o(cnt[g]), .rld_o(rld[g]), .flag_o(flag[g]), .zero_o(zero[g])
      );
    end
  endgenerate

  rt_wave u_wave (
    .clk(clk), .rst_n(srst_n), .zero_i(zero[1]),
    .mode_i(ctrl_q.mode), .wave_o(wave_o)
  );

  assign irq_o = |(flag & ctrl_q.ie);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT0:  rdata = cnt[0];
      A_RLD0:  rdata = rld[0];
      A_CNT1:  rdata = cnt[1];
      A_RLD1:  rdata = rld[1];
      A_CTRL:  rdata = CNT_W'(ctrl_q);
      A_STAT:  rdata = CNT_W'(flag);
      default: rdata = '0;
    endcase
  end

  assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (stat_rd && zero == '0) |=> !irq_o)
    else $error("status read did not drop the request");

  assert_irq_mask_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q.ie == '0) |-> !irq_o)
    else $error("request raised with enables off");
endmodule

// File: tb/reload_timer_top_tb_top.sv
module reload_timer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o, wave_o;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  reload_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .wave_o(wave_o)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 3'(a); rd_en = 1'b1; #1 v = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_change(input int a, output int v, output int c);
    logic [15:0] prev;
    @(negedge clk); addr = 3'(a); #1 prev = rdata;
    v = -1; c = -1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); #1;
      if (rdata != prev) begin v = int'(rdata); c = cyc; break; end
    end
  endtask

  task automatic wait_zero(input int a);
    int v, c;
    for (int i = 0; i < 20; i++) begin
      wait_change(a, v, c);
      if (v == 0 || v < 0) break;
    end
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 6; a++) begin
      rd(a, v); check_eq($sformatf("R1 R10 reg %0d after reset", a), v, 0);
    end
    check_eq("R1 irq after reset", int'(irq_o), 0);
    check_eq("R1 wave after reset", int'(wave_o), 0);
  endtask

  task automatic t_period;
    int v, c, pc;
    wr(0, 100); wr(4, 1);
    wait_change(0, v, pc);
    check_eq("R2 first step value", v, 99);
    for (int k = 0; k < 3; k++) begin
      wait_change(0, v, c);
      check_eq("R2 step value", v, 98 - k);
      check_eq("R2 step spacing", c - pc, 20);
      pc = c;
    end
    wr(4, 0);
  endtask

  task automatic t_reload;
    int v, c;
    int exp_seq[7] = '{1, 0, 3, 2, 1, 0, 3};
    wr(0, 2); wr(1, 3); wr(4, 1);
    for (int k = 0; k < 7; k++) begin
      wait_change(0, v, c);
      check_eq($sformatf("R3 wrap sequence item %0d", k), v, exp_seq[k]);
    end
    wr(4, 0); rd(5, v);
  endtask

  task automatic t_flag_irq;
    int v;
    wr(0, 1); wr(1, 9); wr(4, 5);
    wait_zero(0);
    check_eq("R5 irq with enable on", int'(irq_o), 1);
    wr(4, 4);
    rd(5, v); check_eq("R4 status bit0 set", v, 1);
    check_eq("R4 irq dropped after read", int'(irq_o), 0);
    rd(5, v); check_eq("R4 status cleared", v, 0);
    wr(0, 1); wr(4, 1);
    wait_zero(0);
    check_eq("R5 irq with enable off", int'(irq_o), 0);
    wr(4, 0);
    rd(5, v); check_eq("R5 flag kept with enable off", v, 1);
  endtask

  task automatic t_hold;
    int v;
    wr(4, 0); wr(0, 16'h1234);
    rd(0, v); check_eq("R6 count write readback", v, 16'h1234);
    repeat (60) @(negedge clk);
    rd(0, v); check_eq("R6 disabled count holds", v, 16'h1234);
  endtask

  task automatic t_reload_update;
    int v, c;
    wr(0, 3); wr(1, 2); wr(4, 1);
    wait_change(0, v, c); check_eq("R7 first step", v, 2);
    wr(1, 7);
    rd(0, v); check_eq("R7 count untouched by reload write", v, 2);
    rd(1, v); check_eq("R7 reload readback", v, 7);
    wait_change(0, v, c); check_eq("R7 step", v, 1);
    wait_change(0, v, c); check_eq("R7 zero", v, 0);
    wait_change(0, v, c); check_eq("R7 new reload used", v, 7);
    wr(4, 0); rd(5, v);
  endtask

  task automatic t_wave;
    int v;
    wr(2, 1); wr(3, 1); wr(4, 2 | (1 << 4));
    wait_zero(2); check_eq("R8 toggle first", int'(wave_o), 1);
    wait_zero(2); check_eq("R8 toggle second", int'(wave_o), 0);
    wr(4, 2 | (3 << 4));
    wait_zero(2); check_eq("R8 force high", int'(wave_o), 1);
    wr(4, 2);
    wait_zero(2); check_eq("R8 hold", int'(wave_o), 1);
    wr(4, 2 | (2 << 4));
    wait_zero(2); check_eq("R8 force low", int'(wave_o), 0);
    wr(0, 1); wr(1, 1); wr(4, 1 | (1 << 4));
    wait_zero(0); wait_zero(0);
    check_eq("R8 channel 0 leaves wave alone", int'(wave_o), 0);
    wr(4, 0);
    rd(5, v); check_eq("R4 both status bits", v, 3);
    rd(5, v); check_eq("R4 status cleared again", v, 0);
  endtask

  task automatic t_shared;
    int v, c0, c1;
    wr(0, 50); wr(2, 50); wr(4, 1);
    wait_change(0, v, c0);
    repeat (7) @(negedge clk);
    wr(4, 3);
    wait_change(2, v, c1);
    check_eq("R9 channel 1 first step", v, 49);
    check_eq("R9 shared tick phase", (c1 - c0) % 20, 0);
    wr(4, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_period();
    t_reload();
    t_flag_irq();
    t_hold();
    t_reload_update();
    t_wave();
    t_shared();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule